// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers 18-bit words between a write clock domain and a read clock domain that run with no fixed relation between them; either clock may be the faster one. Words leave in the order they arrived. The write side reports when the buffer is full and when it is more than half full, and it raises a warning when little space is left. The read side reports when the buffer is empty, and it raises a warning when only a few words remain. Both warning thresholds sit in an offset store. Software-free setup is possible: the store takes one of two preset pairs at master reset. The store can also be loaded or read back word-wise over the data buses, or shifted in one bit per write clock.

A mode input is captured during master reset. In standard mode a read request moves the next word into the output register, and the two main flags mean "empty" and "full". In fall-through mode the head word moves to the output on its own, and the same two flags mean "output holds a valid word" and "room for a write". Partial reset empties the buffer and keeps the thresholds and the mode. Retransmit rewinds the read side to the first stored word so the data can be read again.

Top module: `dual_clock_prog_fifo`

## Requirements
- R1: After master reset, standard mode shows rd_flag=1, wr_flag=0, hf=0, pae=1, paf=0. Fall-through mode shows rd_flag=0 and wr_flag=1.
- R2: In standard mode, rd_en high while rd_flag=0 places the oldest word on rd_data at the next rd_clk rising edge. rd_en while rd_flag=1 leaves rd_data unchanged.
- R3: With all 1024 words held, standard-mode wr_flag is 1 and further writes are dropped: exactly the 1024 accepted words read back, in order, then rd_flag returns to 1.
- R4: hf is 1 when more than 512 words are held and 0 at 512 or fewer.
- R5: pae is 1 when the held word count is at or below the empty threshold, and 0 above it.
- R6: paf is 1 when the free space (1024 minus held words) is at or below the full threshold, and 0 above it.
- R7: Master reset loads 7 into both thresholds when def_sel=0, and 127 into both when def_sel=1.
- R8: With ld=1, successive write cycles load the empty threshold and then the full threshold from wr_data[9:0], and store no data. Successive read cycles with ld=1 return the empty threshold and then the full threshold on rd_data[9:0], with upper bits zero.
- R9: With ld=0 and ser_en=1, each wr_clk edge shifts ser_in into bit 0 of the 20-bit chain {full threshold, empty threshold}. The first bit sent ends as bit 9 of the full threshold.
- R10: Partial reset empties the buffer but keeps both thresholds and the mode selected at master reset.
- R11: In fall-through mode, the first word written to an empty buffer is on rd_data with rd_flag=1 by the 4th rd_clk rising edge after the write, with no rd_en. It stays there until rd_en is high on a rising edge, and that edge brings the next word or clears rd_flag.
- R12: A one-cycle rt pulse rewinds the read position to the first word written since the last reset, so later reads start again from that word.
- R13: Data passes without loss, duplication or reordering whether rd_clk is slower or faster than wr_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, held across edges of both clocks |
| prst_n | input | 1 | Partial reset, active low, held across edges of both clocks |
| fwft_sel | input | 1 | Mode captured at master reset: 0 standard, 1 fall-through |
| def_sel | input | 1 | Preset threshold pair at master reset: 0 gives 7, 1 gives 127 |
| wr_en | input | 1 | Write request (data, or a threshold when ld=1) |
| wr_data | input | 18 | Write data |
| ld | input | 1 | Routes word-wise writes and reads to the threshold store |
| ser_en | input | 1 | Enables one serial threshold shift per wr_clk |
| ser_in | input | 1 | Serial threshold bit |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit request, rd_clk domain |
| rd_data | output | 18 | Output register |
| rd_flag | output | 1 | Standard: empty. Fall-through: output word valid |
| wr_flag | output | 1 | Standard: full. Fall-through: room for a write |
| hf | output | 1 | More than half full |
| pae | output | 1 | Almost empty |
| paf | output | 1 | Almost full |

## Verification
A write and a read can land in the same interval. The write side then advances its pointer while the read side advances the other. Each side sees the other's pointer only after two synchronizer stages, so both flags lag and must err on the safe side. The bench provokes this by streaming 200 words with the writer and the reader running at once, first with the read clock slower and then faster than the write clock. The reader issues a request whenever the empty flag is clear. Every word that arrives is compared with the sequence written, so a lost, repeated or reordered word shows up at its position. A read that overtakes the synchronized write pointer shows up the same way.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes nothing beyond standard SystemVerilog packages.
package dcf_pkg;
    // Flag and output timing behaviour captured at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dcf_mode_e;
endpackage

// File: rtl/dcf_ram.sv
// Storage array: one write port on wr_clk, combinational read port.
// Assumes the read side registers rdata; no reset on contents.
module dcf_ram #(
    parameter int DW = 18,
    parameter int AW = 10
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_sync.sv
// Two-stage synchronizer for a Gray-coded pointer, with binary output.
// Assumes the source changes at most one bit per source clock.
module dcf_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1_q, s2_q;

    // Capture the foreign pointer through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_in;
            s2_q <= s1_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < W; i++) bin_out[i] = ^(s2_q >> i);
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Write domain: write pointer, threshold store, full/half/almost-full flags.
// Assumes mrst_n/prst_n are held over several wr_clk edges; the threshold
// outputs are quasi-static for the read domain (changed only while idle).
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DW      = 18,
    parameter int AW      = 10,
    parameter int OFF_LO  = 7,
    parameter int OFF_HI  = 127
) (
    input  logic          wr_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          def_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ld,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [AW:0]   rptr_sync,
    output logic          we,
    output logic [AW:0]   wptr_bin,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output dcf_mode_e     mode,
    output logic          wr_flag,
    output logic          hf,
    output logic          paf
);
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] HALF_P  = {2'b01, {(AW-1){1'b0}}};
    localparam logic [AW:0] ONE_P   = {{AW{1'b0}}, 1'b1};

    logic [AW:0] wcount, free, wnext;
    logic        wfull, lsel_q;

    assign wcount = wptr_bin - rptr_sync;
    assign free   = DEPTH_P - wcount;
    assign wfull  = (wcount == DEPTH_P);
    assign we     = wr_en && !ld && !wfull;
    assign wnext  = wptr_bin + ONE_P;

    // Advance binary and Gray write pointers together on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (!mrst_n || !prst_n) begin
            wptr_bin <= '0;
            wgray    <= '0;
        end else if (we) begin
            wptr_bin <= wnext;
            wgray    <= wnext ^ (wnext >> 1);
        end
    end

    // Threshold store: presets at master reset, word-wise or serial loading.
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) begin
            ae_off <= def_sel ? AW'(OFF_HI) : AW'(OFF_LO);
            af_off <= def_sel ? AW'(OFF_HI) : AW'(OFF_LO);
            lsel_q <= 1'b0;
            mode   <= fwft_sel ? MODE_FWFT : MODE_STD;
        end else if (!prst_n) begin
            lsel_q <= 1'b0;
        end else if (ld && wr_en) begin
            if (!lsel_q) ae_off <= wr_data[AW-1:0];
            else         af_off <= wr_data[AW-1:0];
            lsel_q <= ~lsel_q;
        end else if (ser_en && !ld) begin
            {af_off, ae_off} <= {af_off[AW-2:0], ae_off, ser_in};
        end
    end

    assign wr_flag = (mode == MODE_FWFT) ? !wfull : wfull;
    assign hf      = (wcount > HALF_P);
    assign paf     = (free <= {1'b0, af_off});
endmodule

// File: rtl/dcf_rd_side.sv
// Read domain: read pointer, output register, empty/almost-empty flags,
// retransmit and threshold readback.
// Assumes resets are held over several rd_clk edges and that writes are
// idle around a retransmit (the Gray pointer jumps on rewind).
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 10
) (
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          rd_en,
    input  logic          ld,
    input  logic          rt,
    input  logic [AW:0]   wptr_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr_bin,
    output logic [AW:0]   rgray,
    output logic          mem_empty,
    output dcf_mode_e     mode,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          pae
);
    localparam logic [AW:0] ONE_P = {{AW{1'b0}}, 1'b1};

    logic [AW:0] rcount, total, rnext;
    logic        valid_q, rsel_q, pop, fwft;

    assign fwft      = (mode == MODE_FWFT);
    assign rcount    = wptr_sync - rptr_bin;
    assign mem_empty = (rcount == '0);
    assign pop       = !ld && !rt && !mem_empty && (fwft ? (!valid_q || rd_en) : rd_en);
    assign rnext     = rptr_bin + ONE_P;
    assign raddr     = rptr_bin[AW-1:0];

    // Capture the timing mode at master reset only.
    always_ff @(posedge rd_clk) begin
        if (!mrst_n) mode <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    // Read pointer: clear on reset, rewind on retransmit, step on pop.
    always_ff @(posedge rd_clk) begin
        if (!mrst_n || !prst_n || rt) begin
            rptr_bin <= '0;
            rgray    <= '0;
        end else if (pop) begin
            rptr_bin <= rnext;
            rgray    <= rnext ^ (rnext >> 1);
        end
    end

    // Output register, fall-through valid bit and threshold readback.
    always_ff @(posedge rd_clk) begin
        if (!mrst_n || !prst_n) begin
            rd_data <= '0;
            valid_q <= 1'b0;
            rsel_q  <= 1'b0;
        end else begin
            if (rt) begin
                valid_q <= 1'b0;
            end else if (pop) begin
                rd_data <= ram_rdata;
                valid_q <= fwft;
            end else if (fwft && rd_en && !ld) begin
                valid_q <= 1'b0;
            end
            if (ld && rd_en) begin
                rd_data <= rsel_q ? DW'(af_off) : DW'(ae_off);
                rsel_q  <= ~rsel_q;
            end
        end
    end

    assign total   = rcount + {{AW{1'b0}}, fwft && valid_q};
    assign rd_flag = fwft ? valid_q : mem_empty;
    assign pae     = (total <= {1'b0, ae_off});
endmodule

// File: rtl/dual_clock_prog_fifo.sv
// Top: dual-clock FIFO with programmable almost-empty/almost-full flags,
// standard or fall-through timing, partial reset and retransmit.
// Assumes both resets are held long enough to be seen by both clocks.
module dual_clock_prog_fifo
    import dcf_pkg::*;
#(
    parameter int DW     = 18,
    parameter int AW     = 10,
    parameter int OFF_LO = 7,
    parameter int OFF_HI = 127
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          def_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ld,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic          rd_en,
    input  logic          rt,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          wr_flag,
    output logic          hf,
    output logic          pae,
    output logic          paf
);
    logic [AW:0]   wptr_bin, wgray, rptr_bin, rgray, wptr_sync, rptr_sync;
    logic [AW-1:0] ae_off, af_off, raddr;
    logic [DW-1:0] ram_rdata;
    logic          we, mem_empty, any_rst_n;
    dcf_mode_e     wr_mode, rd_mode;

    assign any_rst_n = mrst_n && prst_n;

    dcf_wr_side #(.DW(DW), .AW(AW), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI)) u_wr (
        .wr_clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .def_sel(def_sel), .wr_en(wr_en), .wr_data(wr_data), .ld(ld),
        .ser_en(ser_en), .ser_in(ser_in), .rptr_sync(rptr_sync), .we(we),
        .wptr_bin(wptr_bin), .wgray(wgray), .ae_off(ae_off), .af_off(af_off),
        .mode(wr_mode), .wr_flag(wr_flag), .hf(hf), .paf(paf)
    );

    dcf_sync #(.W(AW + 1)) u_rptr_to_wr (
        .clk(wr_clk), .rst_n(any_rst_n), .gray_in(rgray), .bin_out(rptr_sync)
    );

    dcf_sync #(.W(AW + 1)) u_wptr_to_rd (
        .clk(rd_clk), .rst_n(any_rst_n), .gray_in(wgray), .bin_out(wptr_sync)
    );

    dcf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wr_clk(wr_clk), .we(we), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
        .raddr(raddr), .rdata(ram_rdata)
    );

    dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .rd_en(rd_en), .ld(ld), .rt(rt), .wptr_sync(wptr_sync), .ae_off(ae_off),
        .af_off(af_off), .ram_rdata(ram_rdata), .raddr(raddr),
        .rptr_bin(rptr_bin), .rgray(rgray), .mem_empty(mem_empty),
        .mode(rd_mode), .rd_data(rd_data), .rd_flag(rd_flag), .pae(pae)
    );
endmodule

// File: rtl/dcf_checker.sv
// Assertion checker bound to dual_clock_prog_fifo.
// Assumes the bench holds resets low from time zero.
module dcf_checker #(
    parameter int DW = 18,
    parameter int AW = 10
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt,
    input logic [DW-1:0] rd_data,
    input logic          rd_flag,
    input logic          wr_flag,
    input logic          hf,
    input logic [AW:0]   wptr_bin,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rptr_bin,
    input logic          mem_empty,
    input logic          wr_fwft,
    input logic          rd_fwft,
    input logic [AW-1:0] ae_off,
    input logic [AW-1:0] af_off
);
    // R3: a write seen while full never moves the write pointer.
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        (wr_en && (wr_fwft ^ wr_flag)) |=> $stable(wptr_bin));

    // R2: with no stored word and no rewind, the read pointer holds.
    p_no_underflow_r2: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (mem_empty && !rt) |=> $stable(rptr_bin));

    // R13: the pointer crossing domains changes at most one bit per edge.
    p_gray_step_r13: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R4: a full buffer in standard mode is always more than half full.
    p_full_implies_half_r4: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        (!wr_fwft && wr_flag) |-> hf);

    // R11: a valid fall-through word is held until it is consumed.
    p_fwft_hold_r11: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (rd_fwft && rd_flag && !rd_en && !rt) |=> (rd_flag && $stable(rd_data)));

    // R10: thresholds do not change while only partial reset is applied.
    p_keep_offsets_r10: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!prst_n) |=> ($stable(ae_off) && $stable(af_off)));
endmodule

bind dual_clock_prog_fifo dcf_checker #(.DW(DW), .AW(AW)) u_dcf_checker (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .wr_en(wr_en), .rd_en(rd_en), .rt(rt), .rd_data(rd_data),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .hf(hf), .wptr_bin(wptr_bin),
    .wgray(wgray), .rptr_bin(rptr_bin), .mem_empty(mem_empty),
    .wr_fwft(wr_mode == dcf_pkg::MODE_FWFT), .rd_fwft(rd_mode == dcf_pkg::MODE_FWFT),
    .ae_off(ae_off), .af_off(af_off)
);

// File: tb/dual_clock_prog_fifo_bench.sv
`timescale 1ns/100ps
module dual_clock_prog_fifo_bench;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1;
    logic        fwft_sel = 1'b0, def_sel = 1'b0;
    logic        wr_en = 1'b0, ld = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
    logic        rd_en = 1'b0, rt = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        rd_flag, wr_flag, hf, pae, paf;
    realtime     rd_half = 3.0;
    int          n_cmp = 0, n_bad = 0;

    always #2 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    dual_clock_prog_fifo u_dual_clock_prog_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_sel(fwft_sel), .def_sel(def_sel), .wr_en(wr_en), .wr_data(wr_data),
        .ld(ld), .ser_en(ser_en), .ser_in(ser_in), .rd_en(rd_en), .rt(rt),
        .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag), .hf(hf),
        .pae(pae), .paf(paf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        repeat (8) @(posedge wr_clk);
        @(negedge wr_clk);
    endtask

    task automatic hold_both();
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
    endtask

    task automatic master_reset(input logic fw, input logic ds);
        @(negedge wr_clk);
        fwft_sel = fw; def_sel = ds; mrst_n = 1'b0;
        wr_en = 0; rd_en = 0; ld = 0; ser_en = 0; rt = 0;
        hold_both();
        mrst_n = 1'b1;
        settle();
    endtask

    task automatic partial_reset();
        @(negedge wr_clk);
        prst_n = 1'b0;
        hold_both();
        prst_n = 1'b1;
        settle();
    endtask

    task automatic push_n(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1; wr_data = 18'(base + i);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int base, input int n);
        @(negedge rd_clk);
        rd_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if (i == n - 1) rd_en = 1'b0;
            chk(tag, 32'(rd_data), 32'(18'(base + i)));
        end
    endtask

    task automatic read_offsets(input string tag, input int ae, input int af);
        @(negedge rd_clk);
        ld = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk);
        chk(tag, 32'(rd_data), 32'(ae));
        @(negedge rd_clk);
        ld = 1'b0; rd_en = 1'b0;
        chk(tag, 32'(rd_data), 32'(af));
    endtask

    task automatic t_reset_std();
        master_reset(1'b0, 1'b0);
        chk("R1 rd_flag", 32'(rd_flag), 1);
        chk("R1 wr_flag", 32'(wr_flag), 0);
        chk("R1 hf", 32'(hf), 0);
        chk("R1 pae", 32'(pae), 1);
        chk("R1 paf", 32'(paf), 0);
    endtask

    task automatic t_std_basic();
        push_n(32'h100, 5);
        settle();
        chk("R2 not empty", 32'(rd_flag), 0);
        read_chk("R2 order", 32'h100, 5);
        settle();
        chk("R2 empty again", 32'(rd_flag), 1);
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
        chk("R2 empty read ignored", 32'(rd_data), 32'h104);
        push_n(32'h200, 7);
        settle();
        chk("R5 pae at threshold", 32'(pae), 1);
        push_n(32'h207, 1);
        settle();
        chk("R5 pae above threshold", 32'(pae), 0);
        read_chk("R5 drain", 32'h200, 8);
    endtask

    task automatic t_full();
        master_reset(1'b0, 1'b0);
        push_n(0, 512);
        settle();
        chk("R4 hf at 512", 32'(hf), 0);
        push_n(512, 1);
        settle();
        chk("R4 hf at 513", 32'(hf), 1);
        push_n(513, 503);
        settle();
        chk("R6 paf free 8", 32'(paf), 0);
        push_n(1016, 1);
        settle();
        chk("R6 paf free 7", 32'(paf), 1);
        push_n(1017, 7);
        settle();
        chk("R3 full flag", 32'(wr_flag), 1);
        push_n(32'h3F000, 3);
        settle();
        read_chk("R3 content", 0, 1024);
        settle();
        chk("R3 extras dropped", 32'(rd_flag), 1);
    endtask

    task automatic t_default_hi();
        master_reset(1'b0, 1'b1);
        read_offsets("R7 presets 127", 127, 127);
        push_n(0, 127);
        settle();
        chk("R7 pae at 127", 32'(pae), 1);
        push_n(127, 1);
        settle();
        chk("R7 pae at 128", 32'(pae), 0);
        master_reset(1'b0, 1'b0);
        read_offsets("R7 presets 7", 7, 7);
    endtask

    task automatic t_parallel();
        @(negedge wr_clk); ld = 1'b1; wr_en = 1'b1; wr_data = 18'd20;
        @(negedge wr_clk); wr_data = 18'd900;
        @(negedge wr_clk); ld = 1'b0; wr_en = 1'b0;
        settle();
        chk("R8 load stores no data", 32'(rd_flag), 1);
        read_offsets("R8 readback", 20, 900);
        push_n(0, 20);
        settle();
        chk("R8 pae at 20", 32'(pae), 1);
        push_n(20, 1);
        settle();
        chk("R8 pae at 21", 32'(pae), 0);
        push_n(21, 102);
        settle();
        chk("R8 paf at 123", 32'(paf), 0);
        push_n(123, 1);
        settle();
        chk("R8 paf at 124", 32'(paf), 1);
    endtask

    task automatic t_partial();
        partial_reset();
        chk("R10 emptied", 32'(rd_flag), 1);
        chk("R10 pae", 32'(pae), 1);
        read_offsets("R10 offsets kept", 20, 900);
    endtask

    task automatic t_serial();
        logic [19:0] chain;
        master_reset(1'b0, 1'b0);
        chain = {10'd50, 10'd3};
        for (int i = 19; i >= 0; i--) begin
            @(negedge wr_clk);
            ser_en = 1'b1; ser_in = chain[i];
        end
        @(negedge wr_clk);
        ser_en = 1'b0;
        settle();
        read_offsets("R9 serial load", 3, 50);
    endtask

    task automatic t_fwft();
        master_reset(1'b1, 1'b0);
        chk("R1 fwft rd_flag", 32'(rd_flag), 0);
        chk("R1 fwft wr_flag", 32'(wr_flag), 1);
        push_n(32'hABC, 1);
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
        chk("R11 first word flag", 32'(rd_flag), 1);
        chk("R11 first word data", 32'(rd_data), 32'hABC);
        repeat (3) @(negedge rd_clk);
        chk("R11 held", 32'(rd_data), 32'hABC);
        push_n(32'hB01, 2);
        settle();
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk);
        chk("R11 next word", 32'(rd_data), 32'hB01);
        @(negedge rd_clk);
        chk("R11 next word 2", 32'(rd_data), 32'hB02);
        @(negedge rd_clk); rd_en = 1'b0;
        chk("R11 consumed", 32'(rd_flag), 0);
        push_n(32'hC00, 2);
        settle();
        partial_reset();
        chk("R10 mode kept rd_flag", 32'(rd_flag), 0);
        chk("R10 mode kept wr_flag", 32'(wr_flag), 1);
    endtask

    task automatic t_retransmit();
        master_reset(1'b0, 1'b0);
        push_n(32'h500, 6);
        settle();
        read_chk("R12 first pass", 32'h500, 3);
        @(negedge rd_clk); rt = 1'b1;
        @(negedge rd_clk); rt = 1'b0;
        read_chk("R12 reread", 32'h500, 6);
    endtask

    task automatic t_stream(input realtime half, input string tag);
        int  got;
        logic pend;
        master_reset(1'b0, 1'b0);
        rd_half = half;
        settle();
        got = 0;
        pend = 1'b0;
        fork
            push_n(32'h1000, 200);
            begin
                while (got < 200) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        chk(tag, 32'(rd_data), 32'(18'(32'h1000 + got)));
                        got++;
                    end
                    pend  = (got < 200) && !rd_flag;
                    rd_en = pend;
                end
                rd_en = 1'b0;
            end
        join
        settle();
        chk({tag, " drained"}, 32'(rd_flag), 1);
    endtask

    initial begin
        #600us;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset_std();
        t_std_basic();
        t_full();
        t_default_hi();
        t_parallel();
        t_partial();
        t_serial();
        t_fwft();
        t_retransmit();
        t_stream(5.0, "R13 slow read");
        t_stream(1.5, "R13 fast read");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule